// File: doc/BRIEF.md
# UART interrupt status and mask unit

This block turns the fill levels and error events of a UART into one level-sensitive interrupt line. It compares the receive and transmit FIFO occupancy counts with two programmable trigger levels and forms a live status word from the result. Each cycle it ORs the live flags and any event pulses into a sticky interrupt register. Software clears that register one bit at a time by writing ones.

A mask register selects which sticky bits can raise the interrupt. Software never writes the mask directly. One register offset sets mask bits and another clears them, so a driver can change one source without a read-modify-write. All registers sit behind a simple single-cycle write/read port with byte-offset addressing. Reads are combinational and have no side effects.

The block does not contain the FIFOs or any serial line logic. It only observes the counts and event strobes they produce.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word (offset 0x10, read-only) is formed combinationally from the current inputs. Bit 0 = RX count >= RX trigger level. Bit 1 = RX count is zero. Bit 2 = RX count equals RX_DEPTH. Bit 3 = TX count is zero. Bit 4 = TX count equals TX_DEPTH. All other bits are zero except bit 13 (R2).
- R2: Status bit 13 is set when TX count >= TX trigger level. This flag is captured into sticky bit 10, not bit 13.
- R3: On every clock edge, status bits 4:0 are ORed into sticky bits 4:0 (offset 0x0C). A sticky bit stays set after its condition goes away.
- R4: A write to offset 0x0C clears each sticky bit written as one. If the condition behind a bit still holds, that bit is set again in the same cycle.
- R5: Event pulses set these sticky bits: RX overrun bit 5, framing error bit 6, parity error bit 7, RX timeout bit 8, modem status change bit 9, TX overrun bit 12. The bit is visible from the edge on which the pulse is sampled.
- R6: When an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x00 sets the mask bits written as one. A write to offset 0x04 clears them. The mask reads at offset 0x08, and writes to 0x08 leave it unchanged.
- R8: The output irq is high exactly when some bit is set in both the mask and the sticky register.
- R9: During and right after reset, the mask and sticky registers are zero, both trigger levels read 32, and irq is low.
- R10: The RX trigger level (offset 0x14) and TX trigger level (offset 0x18) are writable and read back. Changing them immediately changes status bits 0 and 13. Reads never change any register.
- R11: Bit 11 and bits above 12 of the mask and sticky registers always read zero. Offsets 0x00, 0x04 and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| evt_rx_overrun | input | 1 | One-cycle receive overrun event |
| evt_framing | input | 1 | One-cycle framing error event |
| evt_parity | input | 1 | One-cycle parity error event |
| evt_rx_timeout | input | 1 | One-cycle receive timeout event |
| evt_modem | input | 1 | One-cycle modem status change event |
| evt_tx_overrun | input | 1 | One-cycle transmit overrun event |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets three corner cases.

- The TX trigger flag moves from status bit 13 to sticky bit 10. A design that copied positions straight across would light bit 13 of the sticky register and never raise the masked interrupt for that source.
- Clearing must race correctly against both a persisting level condition and a same-cycle event pulse. A design that let the clear win would lose an overrun that arrived while software was acknowledging it.
- The mask must ignore direct writes, and disabling a source must drop irq without touching the sticky bit. Empty and full levels at the exact FIFO depth, and trigger levels of zero, check the comparison boundaries.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int REG_W = 32;
  localparam int INT_W = 13;

  // byte offsets
  localparam logic [7:0] OFS_IEN    = 8'h00;
  localparam logic [7:0] OFS_IDIS   = 8'h04;
  localparam logic [7:0] OFS_MASK   = 8'h08;
  localparam logic [7:0] OFS_STICKY = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_RXTRIG = 8'h14;
  localparam logic [7:0] OFS_TXTRIG = 8'h18;

  // live status positions
  localparam int ST_RX_TRIG  = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_EMPTY = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_TX_TRIG  = 13;

  // sticky positions beyond the shared low field
  localparam int IS_RX_OVR  = 5;
  localparam int IS_FRAME   = 6;
  localparam int IS_PARITY  = 7;
  localparam int IS_RX_TMO  = 8;
  localparam int IS_MODEM   = 9;
  localparam int IS_TX_TRIG = 10;
  localparam int IS_TX_OVR  = 12;

  localparam logic [INT_W-1:0] INT_IMPL = 13'h17FF;

  typedef struct packed {
    logic tx_ovr;
    logic modem;
    logic rx_tmo;
    logic parity;
    logic frame;
    logic rx_ovr;
  } evt_t;

endpackage

// File: rtl/uirq_status_eval.sv
module uirq_status_eval
  import uart_irq_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  evt_t             evt_i,
  output logic [REG_W-1:0] status_o,
  output logic [INT_W-1:0] set_o
);

  function automatic logic [REG_W-1:0] level_flags(
    input logic [CNT_W-1:0] rxc, input logic [CNT_W-1:0] txc,
    input logic [CNT_W-1:0] rxt, input logic [CNT_W-1:0] txt);
    logic [REG_W-1:0] s;
    s = '0;
    s[ST_RX_TRIG]  = (rxc >= rxt);
    s[ST_RX_EMPTY] = (rxc == '0);
    s[ST_RX_FULL]  = (rxc == CNT_W'(RX_DEPTH));
    s[ST_TX_EMPTY] = (txc == '0);
    s[ST_TX_FULL]  = (txc == CNT_W'(TX_DEPTH));
    s[ST_TX_TRIG]  = (txc >= txt);
    return s;
  endfunction

  function automatic logic [INT_W-1:0] to_sticky(
    input logic [REG_W-1:0] s, input evt_t e);
    logic [INT_W-1:0] v;
    v = '0;
    v[4:0]        = s[4:0];
    v[IS_TX_TRIG] = s[ST_TX_TRIG];
    v[IS_RX_OVR]  = e.rx_ovr;
    v[IS_FRAME]   = e.frame;
    v[IS_PARITY]  = e.parity;
    v[IS_RX_TMO]  = e.rx_tmo;
    v[IS_MODEM]   = e.modem;
    v[IS_TX_OVR]  = e.tx_ovr;
    return v;
  endfunction

  assign status_o = level_flags(rx_cnt_i, tx_cnt_i, rx_trig_i, tx_trig_i);
  assign set_o    = to_sticky(status_o, evt_i);

  // R1
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[ST_RX_EMPTY] && status_o[ST_RX_FULL]) &&
    !(status_o[ST_TX_EMPTY] && status_o[ST_TX_FULL]));

endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));

  // R6
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(set_i) & ~q_o) == '0));

endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
  parameter int           W    = 13,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= ((q_o | set_i) & ~clr_i) & IMPL;
  end

  // R7
  mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(set_i) == '0) && ($past(clr_i) == '0)) |-> $stable(q_o));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int TRIG_RST = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = $clog2((RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              evt_rx_overrun,
  input  logic              evt_framing,
  input  logic              evt_parity,
  input  logic              evt_rx_timeout,
  input  logic              evt_modem,
  input  logic              evt_tx_overrun,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam logic [CNT_W-1:0] TRIG_INIT = CNT_W'(TRIG_RST);

  evt_t             evt;
  logic [REG_W-1:0] status_w;
  logic [INT_W-1:0] set_vec;
  logic [INT_W-1:0] sticky_q;
  logic [INT_W-1:0] mask_q;
  logic [CNT_W-1:0] rx_trig_q;
  logic [CNT_W-1:0] tx_trig_q;
  logic             wr_ien, wr_idis, wr_sticky, wr_rxtrig, wr_txtrig;
  logic [INT_W-1:0] wdata_int;
  logic             unused_hi;

  assign evt = '{tx_ovr: evt_tx_overrun, modem: evt_modem, rx_tmo: evt_rx_timeout,
                 parity: evt_parity, frame: evt_framing, rx_ovr: evt_rx_overrun};

  assign wdata_int = reg_wdata[INT_W-1:0];
  assign unused_hi = ^reg_wdata[31:INT_W];

  assign wr_ien    = reg_wr && (reg_addr == ADDR_W'(OFS_IEN));
  assign wr_idis   = reg_wr && (reg_addr == ADDR_W'(OFS_IDIS));
  assign wr_sticky = reg_wr && (reg_addr == ADDR_W'(OFS_STICKY));
  assign wr_rxtrig = reg_wr && (reg_addr == ADDR_W'(OFS_RXTRIG));
  assign wr_txtrig = reg_wr && (reg_addr == ADDR_W'(OFS_TXTRIG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig_q <= TRIG_INIT;
      tx_trig_q <= TRIG_INIT;
    end else begin
      if (wr_rxtrig) rx_trig_q <= reg_wdata[CNT_W-1:0];
      if (wr_txtrig) tx_trig_q <= reg_wdata[CNT_W-1:0];
    end
  end

  uirq_status_eval #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .CNT_W(CNT_W)) u_eval (
    .clk(clk), .rst_n(rst_n),
    .rx_cnt_i(rx_count), .tx_cnt_i(tx_count),
    .rx_trig_i(rx_trig_q), .tx_trig_i(tx_trig_q),
    .evt_i(evt), .status_o(status_w), .set_o(set_vec)
  );

  uirq_sticky #(.W(INT_W)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_i(set_vec),
    .clr_i(wr_sticky ? wdata_int : '0),
    .q_o(sticky_q)
  );

  uirq_mask #(.W(INT_W), .IMPL(INT_IMPL)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_i(wr_ien ? wdata_int : '0),
    .clr_i(wr_idis ? wdata_int : '0),
    .q_o(mask_q)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_MASK):   reg_rdata = 32'(mask_q);
      ADDR_W'(OFS_STICKY): reg_rdata = 32'(sticky_q);
      ADDR_W'(OFS_STATUS): reg_rdata = status_w;
      ADDR_W'(OFS_RXTRIG): reg_rdata = 32'(rx_trig_q);
      ADDR_W'(OFS_TXTRIG): reg_rdata = 32'(tx_trig_q);
      default:             reg_rdata = '0;
    endcase
  end

  assign irq = |(mask_q & sticky_q);

  // R2
  tx_trig_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(status_w[ST_TX_TRIG])) |-> sticky_q[IS_TX_TRIG]);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((mask_q != '0) && (sticky_q != '0)));

  // R11
  reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_q[11] && !mask_q[11]);

endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [CW-1:0] tx_count = '0;
  logic [5:0]    ev = '0; // 0 rxovr,1 frame,2 parity,3 rxtmo,4 modem,5 txovr
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rx_count(rx_count), .tx_count(tx_count),
    .evt_rx_overrun(ev[0]), .evt_framing(ev[1]), .evt_parity(ev[2]),
    .evt_rx_timeout(ev[3]), .evt_modem(ev[4]), .evt_tx_overrun(ev[5]),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // rx[31:24] tx[23:16] expected status[15:0], triggers at 32, depth 64
  localparam logic [31:0] VEC [7] = '{
    {8'd0,  8'd0,  16'h000A},
    {8'd32, 8'd0,  16'h0009},
    {8'd64, 8'd0,  16'h000D},
    {8'd5,  8'd64, 16'h2010},
    {8'd31, 8'd32, 16'h2000},
    {8'd0,  8'd31, 16'h0002},
    {8'd63, 8'd1,  16'h0001}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pos [6] = '{5, 6, 7, 8, 9, 12};

    // R9 reset state
    repeat (2) @(negedge clk);
    rd(8'h08, v); chk("R9 mask", v, 32'h0);
    rd(8'h0C, v); chk("R9 sticky", v, 32'h0);
    rd(8'h14, v); chk("R9 rxtrig", v, 32'd32);
    rd(8'h18, v); chk("R9 txtrig", v, 32'd32);
    chk("R9 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;

    // R1 R2 table walk
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      rx_count = VEC[i][30:24];
      tx_count = VEC[i][22:16];
      rd(8'h10, v);
      chk("R1 R2 status", v, {16'h0, VEC[i][15:0]});
    end
    @(negedge clk);
    rx_count = 7'd10; tx_count = 7'd10;
    rd(8'h0C, v); chk("R3 accumulated sticky", v, 32'h041F);
    rd(8'h10, v); chk("R1 quiet status", v, 32'h0);

    // R4 clear
    wr(8'h0C, 32'hFFFF);
    rd(8'h0C, v); chk("R4 cleared", v, 32'h0);
    @(negedge clk);
    rd(8'h0C, v); chk("R3 no spurious set", v, 32'h0);

    // R2 tx trigger lands on bit 10
    tx_count = 7'd40;
    @(negedge clk);
    rd(8'h0C, v); chk("R2 sticky bit10", v, 32'h0400);
    rd(8'h10, v); chk("R2 status bit13", v, 32'h2000);
    wr(8'h0C, 32'h0400);
    rd(8'h0C, v); chk("R4 persisting condition resets bit", v, 32'h0400);
    tx_count = 7'd10;
    wr(8'h0C, 32'h0400);
    rd(8'h0C, v); chk("R4 clear after condition gone", v, 32'h0);

    // R5 event positions
    for (int k = 0; k < 6; k++) begin
      pulse(k);
      rd(8'h0C, v); chk("R5 event bit", v, 32'h1 << pos[k]);
      wr(8'h0C, 32'hFFFF);
    end

    // R6 event beats clear
    pulse(0);
    @(negedge clk);
    reg_addr = 8'h0C; reg_wdata = 32'h20; reg_wr = 1'b1; ev[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev = '0;
    rd(8'h0C, v); chk("R6 event wins", v, 32'h20);
    wr(8'h0C, 32'h20);
    rd(8'h0C, v); chk("R6 later clear", v, 32'h0);

    // R7 mask set/clear/ignore
    wr(8'h00, 32'h60);
    rd(8'h08, v); chk("R7 enable", v, 32'h60);
    wr(8'h04, 32'h20);
    rd(8'h08, v); chk("R7 disable", v, 32'h40);
    wr(8'h08, 32'hFFFF);
    rd(8'h08, v); chk("R7 direct write ignored", v, 32'h40);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R11 reserved mask bits", v, 32'h17FF);

    // R8 interrupt
    chk("R8 irq low no sticky", 32'(irq), 32'h0);
    pulse(1);
    #1 chk("R8 irq high", 32'(irq), 32'h1);
    wr(8'h04, 32'h40);
    chk("R8 irq low masked", 32'(irq), 32'h0);
    rd(8'h0C, v); chk("R8 sticky kept", v, 32'h40);
    wr(8'h00, 32'h40);
    chk("R8 irq re-enabled", 32'(irq), 32'h1);
    wr(8'h0C, 32'h40);
    chk("R8 irq after clear", 32'(irq), 32'h0);

    // R10 triggers and side-effect-free reads
    wr(8'h14, 32'd8);
    rd(8'h14, v); chk("R10 rxtrig readback", v, 32'd8);
    rd(8'h10, v); chk("R10 status rxtrig", v, 32'h0001);
    @(negedge clk);
    rd(8'h0C, v); chk("R10 sticky read 1", v, 32'h0001);
    rd(8'h0C, v); chk("R10 sticky read 2", v, 32'h0001);
    wr(8'h18, 32'd0);
    rd(8'h18, v); chk("R10 txtrig readback", v, 32'd0);
    rd(8'h10, v); chk("R10 txtrig zero", v, 32'h2001);

    // R11 zero reads
    rd(8'h1C, v); chk("R11 unmapped", v, 32'h0);
    rd(8'h00, v); chk("R11 enable reads zero", v, 32'h0);
    wr(8'h00, 32'h800);
    rd(8'h08, v); chk("R11 mask bit11", v & 32'h800, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule